// File: doc/BRIEF.md
# Indexed Gather/Scatter Memory Unit

This unit moves individual 32-bit words between an on-chip data buffer and an external memory that can only be accessed one whole burst at a time. The external addresses are not a linear range: each comes from an on-chip index buffer, one index per element, so the access pattern depends on the data. In gather mode, element i of the data buffer receives the external word named by index i. In scatter mode, element i of the data buffer is written to the external word named by index i.

Each index is split into a burst address (upper bits) and a word lane inside the 16-word burst (lower four bits). Runs of consecutive indices that fall in the same burst are coalesced. A gather run is served by a single burst read. A scatter run is collected into one burst write whose per-lane strobe marks only the words that were touched. A controller starts a job with a mode bit and an element count, and waits for a one-cycle completion pulse.

Top module: `idx_gather_scatter`

## Requirements
- R1: In gather mode, data buffer entry i receives the external word idx[i]. The burst address is idx >> 4 and the lane is idx[3:0]. Lane l of a burst sits at bits [32*l+31 : 32*l] of the burst data.
- R2: In scatter mode, data buffer entry i is written to external word idx[i] by a burst write. Strobe bit l enables lane l, and every lane whose strobe bit is 0 is left unchanged in external memory.
- R3: Consecutive indices that map to the same burst share one memory access. The number of burst reads (gather) or burst writes (scatter) equals the number of runs of equal burst address in the index list. A burst that is revisited after a different burst counts again.
- R4: Gather writes the data buffer exactly once per element, in ascending entry order, even when several elements come from the same open burst.
- R5: In scatter mode, when two elements of one coalesced run target the same word, the later element's value is the one stored.
- R6: A memory request keeps its address, direction, data and strobe stable until it is granted. Read data is taken on the read-valid pulse, and only one request is outstanding at a time.
- R7: `done` pulses high for one cycle after the last element has finished, including the final burst write of a scatter. A start with count 0 raises `done` on the next cycle, with no memory or buffer traffic.
- R8: A start that arrives while a job is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a job when idle |
| is_scatter | input | 1 | 1 = scatter, 0 = gather; sampled at start |
| count | input | 7 | Number of elements (0 to 64); sampled at start |
| done | output | 1 | One-cycle completion pulse |
| ix_rd_addr | output | 6 | Index buffer read address (combinational read) |
| ix_rd_data | input | 10 | Index buffer read data (word address) |
| db_rd_addr | output | 6 | Data buffer read address (combinational read) |
| db_rd_data | input | 32 | Data buffer read data |
| db_wr_en | output | 1 | Data buffer write enable |
| db_wr_addr | output | 6 | Data buffer write address |
| db_wr_data | output | 32 | Data buffer write data |
| mem_req | output | 1 | Burst request valid |
| mem_we | output | 1 | 1 = burst write, 0 = burst read |
| mem_addr | output | 6 | Burst address |
| mem_wdata | output | 512 | Burst write data |
| mem_wstrb | output | 16 | Per-lane write strobe |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read burst data valid |
| mem_rdata | input | 512 | Read burst data |

## Verification
The bench drives index lists that stay in one burst, that hop back and forth between two bursts, and that stride across many bursts. It counts burst reads and writes against the number of runs, so a design that refetched on every element, or failed to refetch a revisited burst, would be caught. Scatter results are compared over the whole external array against a background pattern, which exposes a design that wrote a full burst and wiped the neighbouring words, or that let an earlier duplicate win. The bench also targets the extreme lanes and addresses (word 0, word 1023), a zero count that must complete at once, a start issued while a job is running, and a memory that only grants on every other cycle, where a design that changed its request before the grant would corrupt the data.

// File: rtl/idx_gather_scatter.sv
module idx_gather_scatter #(
  parameter int WORD_W = 32,
  parameter int LANES  = 16,
  parameter int IDX_W  = 10,
  parameter int DEPTH  = 64,
  localparam int LANE_W   = $clog2(LANES),
  localparam int BURST_AW = IDX_W - LANE_W,
  localparam int LINE_W   = LANES * WORD_W,
  localparam int BUF_AW   = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                is_scatter,
  input  logic [CNT_W-1:0]    count,
  output logic                done,
  output logic [BUF_AW-1:0]   ix_rd_addr,
  input  logic [IDX_W-1:0]    ix_rd_data,
  output logic [BUF_AW-1:0]   db_rd_addr,
  input  logic [WORD_W-1:0]   db_rd_data,
  output logic                db_wr_en,
  output logic [BUF_AW-1:0]   db_wr_addr,
  output logic [WORD_W-1:0]   db_wr_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [BURST_AW-1:0] mem_addr,
  output logic [LINE_W-1:0]   mem_wdata,
  output logic [LANES-1:0]    mem_wstrb,
  input  logic                mem_gnt,
  input  logic                mem_rvalid,
  input  logic [LINE_W-1:0]   mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_RD, S_RDW, S_WR} state_t;

  state_t                          state;
  logic                            mode;
  logic [CNT_W-1:0]                cnt, pos;
  logic                            line_ok;
  logic [BURST_AW-1:0]             line_addr, pend_addr;
  logic [LANES-1:0][WORD_W-1:0]    line_data, pend_data;
  logic [LANES-1:0]                pend_strb;

  logic [BURST_AW-1:0] cur_burst;
  logic [LANE_W-1:0]   cur_lane;
  logic                at_end, line_hit, pend_fit;

  assign cur_burst = ix_rd_data[IDX_W-1:LANE_W];
  assign cur_lane  = ix_rd_data[LANE_W-1:0];
  assign at_end    = (pos == cnt);
  assign line_hit  = line_ok && (line_addr == cur_burst);
  assign pend_fit  = (pend_strb == '0) || (pend_addr == cur_burst);

  assign ix_rd_addr = pos[BUF_AW-1:0];
  assign db_rd_addr = pos[BUF_AW-1:0];
  assign db_wr_en   = (state == S_RUN) && !mode && !at_end && line_hit;
  assign db_wr_addr = pos[BUF_AW-1:0];
  assign db_wr_data = line_data[cur_lane];

  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = mem_we ? pend_addr : cur_burst;
  assign mem_wdata = pend_data;
  assign mem_wstrb = mem_we ? pend_strb : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mode      <= 1'b0;
      cnt       <= '0;
      pos       <= '0;
      done      <= 1'b0;
      line_ok   <= 1'b0;
      line_addr <= '0;
      line_data <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_strb <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mode      <= is_scatter;
          cnt       <= count;
          pos       <= '0;
          line_ok   <= 1'b0;
          pend_strb <= '0;
          if (count == '0) done <= 1'b1;
          else             state <= S_RUN;
        end
        S_RUN: begin
          if (at_end) begin
            if (mode && (pend_strb != '0)) state <= S_WR;
            else begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end else if (!mode) begin
            if (line_hit) pos <= pos + 1'b1;
            else          state <= S_RD;
          end else if (pend_fit) begin
            pend_addr            <= cur_burst;
            pend_data[cur_lane]  <= db_rd_data;
            pend_strb[cur_lane]  <= 1'b1;
            pos                  <= pos + 1'b1;
          end else begin
            state <= S_WR;
          end
        end
        S_RD: if (mem_gnt) state <= S_RDW;
        S_RDW: if (mem_rvalid) begin
          line_data <= mem_rdata;
          line_addr <= cur_burst;
          line_ok   <= 1'b1;
          state     <= S_RUN;
        end
        S_WR: if (mem_gnt) begin
          pend_strb <= '0;
          if (at_end) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_RUN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: request held stable until granted
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wstrb) && $stable(mem_wdata)));

  // R2: a burst write always carries at least one enabled lane
  a_r2_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wstrb != '0));

  // R4: back-to-back buffer writes advance by exactly one entry
  a_r4_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    db_wr_en |=> (!db_wr_en || (db_wr_addr == $past(db_wr_addr) + 1'b1)));

  // R7: zero count completes on the following cycle
  a_r7_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && count == '0) |=> done);

  // R6: no buffer write while a memory request is pending
  a_r6_one_thing: assert property (@(posedge clk) disable iff (!rst_n)
    db_wr_en |-> !mem_req);

endmodule

// File: tb/idx_gather_scatter_tb_top.sv
module idx_gather_scatter_tb_top;
  localparam int W = 32, L = 16, IW = 10, D = 64;
  localparam int NW = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, is_scatter = 1'b0;
  logic [6:0] count = '0;
  logic done, db_wr_en, mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [5:0] ix_rd_addr, db_rd_addr, db_wr_addr, mem_addr;
  logic [IW-1:0] ix_rd_data;
  logic [W-1:0] db_rd_data, db_wr_data;
  logic [L*W-1:0] mem_wdata, mem_rdata;
  logic [L-1:0] mem_wstrb;

  logic [IW-1:0] idx_mem [D];
  logic [W-1:0]  dbuf [D];
  logic [W-1:0]  ext [NW];
  logic [W-1:0]  ref_m [NW];
  logic [W-1:0]  dref [D];

  int checks = 0, failures = 0, rd_count = 0, wr_count = 0, cyc = 0;
  logic stall = 1'b0, gnt_en = 1'b1;
  int rd_wait = 0;
  logic [5:0] rd_addr_q = '0;

  assign ix_rd_data = idx_mem[ix_rd_addr];
  assign db_rd_data = dbuf[db_rd_addr];
  assign mem_gnt = mem_req & gnt_en;

  idx_gather_scatter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_scatter(is_scatter), .count(count),
    .done(done), .ix_rd_addr(ix_rd_addr), .ix_rd_data(ix_rd_data),
    .db_rd_addr(db_rd_addr), .db_rd_data(db_rd_data), .db_wr_en(db_wr_en),
    .db_wr_addr(db_wr_addr), .db_wr_data(db_wr_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    gnt_en <= stall ? ~gnt_en : 1'b1;
    if (db_wr_en) dbuf[db_wr_addr] <= db_wr_data;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt && mem_we) begin
      wr_count <= wr_count + 1;
      for (int l = 0; l < L; l++)
        if (mem_wstrb[l]) ext[mem_addr*L + l] <= mem_wdata[l*W +: W];
    end
    if (mem_req && mem_gnt && !mem_we) begin
      rd_count <= rd_count + 1;
      rd_addr_q <= mem_addr;
      rd_wait <= 2;
    end else if (rd_wait != 0) begin
      rd_wait <= rd_wait - 1;
      if (rd_wait == 1) begin
        mem_rvalid <= 1'b1;
        for (int l = 0; l < L; l++) mem_rdata[l*W +: W] <= ext[rd_addr_q*L + l];
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    failures++;
    $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
    summary();
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_ext();
    for (int k = 0; k < NW; k++) ext[k] = 32'h5000_0000 + k * 7;
  endtask

  function automatic int runs(input int n);
    int r = 0;
    for (int i = 0; i < n; i++)
      if (i == 0 || (idx_mem[i] >> 4) != (idx_mem[i-1] >> 4)) r++;
    return r;
  endfunction

  task automatic run_job(input bit sc, input int n, input bit poke);
    int t = 0;
    rd_count = 0; wr_count = 0;
    @(negedge clk);
    is_scatter = sc; count = 7'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      is_scatter = ~sc; count = 7'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check(done === 1'b1, "R7 done seen", done, 1);
    @(negedge clk);
    check(done === 1'b0, "R7 done one cycle", done, 0);
  endtask

  task automatic do_gather(input string name, input int n, input bit poke);
    for (int k = 0; k < NW; k++) ref_m[k] = ext[k];
    for (int i = 0; i < D; i++) dbuf[i] = 32'hDEAD_0000 + i;
    run_job(1'b0, n, poke);
    begin
      int bad = 0;
      for (int i = 0; i < D; i++) begin
        dref[i] = (i < n) ? ref_m[idx_mem[i]] : 32'hDEAD_0000 + i;
        if (dbuf[i] !== dref[i]) begin
          bad++;
          if (bad == 1) check(0, {"R1 R4 gather ", name}, dbuf[i], dref[i]);
        end
      end
      if (bad == 0) check(1, "R1", 0, 0);
    end
    check(rd_count == runs(n), {"R3 read count ", name}, rd_count, runs(n));
    check(wr_count == 0, {"R8 no writes in gather ", name}, wr_count, 0);
  endtask

  task automatic do_scatter(input string name, input int n);
    fill_ext();
    for (int k = 0; k < NW; k++) ref_m[k] = ext[k];
    for (int i = 0; i < n; i++) ref_m[idx_mem[i]] = dbuf[i];
    run_job(1'b1, n, 1'b0);
    begin
      int bad = 0;
      for (int k = 0; k < NW; k++)
        if (ext[k] !== ref_m[k]) begin
          bad++;
          if (bad == 1) check(0, {"R2 R5 scatter ", name}, ext[k], ref_m[k]);
        end
      if (bad == 0) check(1, "R2", 0, 0);
    end
    check(wr_count == runs(n), {"R3 write count ", name}, wr_count, runs(n));
    check(rd_count == 0, {"R3 no reads in scatter ", name}, rd_count, 0);
  endtask

  initial begin
    fill_ext();
    for (int i = 0; i < D; i++) begin idx_mem[i] = '0; dbuf[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 0 && mem_req == 0 && db_wr_en == 0, "reset idle", {done, mem_req, db_wr_en}, 0);

    // stride 3 across many bursts
    for (int i = 0; i < D; i++) idx_mem[i] = IW'(3 * i);
    do_gather("stride", 64, 0);

    // one burst, repeated lanes -> single read
    idx_mem[0] = 10'd37; idx_mem[1] = 10'd37; idx_mem[2] = 10'd34;
    idx_mem[3] = 10'd47; idx_mem[4] = 10'd32; idx_mem[5] = 10'd40;
    do_gather("same burst", 6, 0);

    // alternating bursts: revisit refetches
    idx_mem[0] = 10'd5; idx_mem[1] = 10'd100; idx_mem[2] = 10'd6; idx_mem[3] = 10'd7;
    do_gather("alternate", 4, 0);

    // extreme addresses and lanes
    idx_mem[0] = 10'd1023; idx_mem[1] = 10'd0; idx_mem[2] = 10'd1008; idx_mem[3] = 10'd15;
    do_gather("edges", 4, 0);

    // stalled grants plus a start while busy (R8)
    stall = 1'b1;
    for (int i = 0; i < D; i++) idx_mem[i] = IW'((i * 37) % NW);
    do_gather("stall busy start R8", 64, 1);

    // scatter with stride, stalled
    for (int i = 0; i < D; i++) begin idx_mem[i] = IW'(3 * i); dbuf[i] = 32'hA000_0000 + i; end
    do_scatter("stride", 64);
    stall = 1'b0;

    // duplicate word inside one run: later wins (R5)
    idx_mem[0] = 10'd200; idx_mem[1] = 10'd201; idx_mem[2] = 10'd200; idx_mem[3] = 10'd1023;
    dbuf[0] = 32'h1111; dbuf[1] = 32'h2222; dbuf[2] = 32'h3333; dbuf[3] = 32'h4444;
    do_scatter("dup R5", 4);

    // zero count: done next cycle, no traffic
    rd_count = 0; wr_count = 0;
    @(negedge clk);
    is_scatter = 1'b0; count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R7 zero count done", done, 1);
    @(negedge clk);
    check(done === 1'b0, "R7 zero count pulse", done, 0);
    repeat (4) @(negedge clk);
    check(rd_count == 0 && wr_count == 0, "R7 zero count traffic", rd_count + wr_count, 0);

    summary();
  end
endmodule